// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequence Decoder

This block sits behind the asynchronous-style byte bus of a single-supply parallel NOR flash and turns multi-cycle write sequences into single-cycle operation requests. The bus strobes are sampled by the block clock. A write is open while chip select and write strobe are both low and output enable is high. The address is taken in the first cycle of that window and the data in its last cycle. Each completed write goes to a sequence tracker. The tracker follows the two unlock cycles and the setup codes. When a sequence is complete it raises a one-cycle request that carries an operation kind, an address and a data byte.

The tracker also serves the identification mode. While that mode is active, reads return the manufacturer code, the device code or the protect flag of the addressed sector instead of array data. Operation timing, status reporting and the array itself are outside this block. An external controller reports through `busy_in` that an operation is running and through `suspended_in` that a sector erase is on hold. Those two flags decide which commands the tracker accepts. For a byte program the block reads the old byte through `look_addr` / `arr_rdata` and issues the AND of old and new data, because programming can only clear bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `req_valid` and `id_valid` are 0 and `req_kind` is 0 (none). Request kinds are 1 program, 2 chip erase, 3 sector erase, 4 suspend, 5 resume, 6 reset.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then data D at address A raises one program request (kind 1) with `req_addr`=A and `req_data` = D AND the old byte. Only the low 11 address bits are compared on unlock and setup cycles.
- R3: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h raises one chip erase request (kind 2).
- R4: The same erase prefix ending in 30h at any address raises a sector erase request (kind 3) with that address. Until `busy_in` rises, each further 30h adds another sector erase request and B0h raises suspend (kind 4). Any other write in this window raises a reset request and closes the window.
- R5: A wrong address, a wrong data value or a wrong cycle order returns the tracker to array-read with no request. The next correct sequence is then decoded normally.
- R6: F0h written at any address part way through a sequence aborts it and raises a reset request (kind 6), provided `suspended_in` is 0.
- R7: While `busy_in` is 1, every write is ignored, F0h included. The one exception is B0h while the running operation is a sector erase and `suspended_in` is 0, which raises suspend.
- R8: After AAh@555h, 55h@2AAh, 90h@555h, a read (chip select and output enable low) returns one cycle later, with `id_valid`=1: the manufacturer code at offset 00h, the device code at 01h, and 01h or 00h at 02h for a protected or unprotected sector (sector number = top SECT_W address bits). Other offsets return 00h. Without a read, `id_valid` is 0.
- R9: Identification mode is left only by F0h. Other writes leave it active.
- R10: While `suspended_in` is 1, the program and identification sequences are accepted and 30h at any address raises resume (kind 5). Erase sequences raise nothing, and leaving identification mode raises no request.
- R11: A strobe made while output enable is low is not a write and has no effect on the sequence.
- R12: The address is the one present when the write window opens. The data is the one present in its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | 8 | Bus write data |
| busy_in | input | 1 | An operation is running |
| suspended_in | input | 1 | A sector erase is on hold |
| sector_prot | input | 2**SECT_W | Protect flag per sector |
| arr_rdata | input | 8 | Array byte at `look_addr` |
| look_addr | output | ADDR_W | Address of the write in progress |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 3 | Request kind |
| req_addr | output | ADDR_W | Request address |
| req_data | output | 8 | Request data (program: old AND new) |
| id_valid | output | 1 | Identification read data valid |
| id_data | output | 8 | Identification read data |

## Verification
The bench targets the fallbacks. These include a near-miss unlock address, a wrong unlock value, a second cycle arriving first, and a setup code written from idle. A decoder that keeps partial state through any of these would issue a spurious program. It also drives F0h and B0h while busy; a design that honours them there would abort or hold a chip erase. Inside the sector-erase window it writes both extra sectors and a stray command. It moves address and data within one strobe; getting this wrong programs the wrong byte. Last, it leaves identification mode while suspended; a design that gets this wrong would issue a reset and drop the held erase.

// File: rtl/flash_cmd_pkg.sv
// Package: shared constants and types of the flash command decoder.
// Assumes unlock and setup addresses are compared on the low 11 bits.
package flash_cmd_pkg;

    localparam int UNLK_W = 11;
    localparam logic [UNLK_W-1:0] UNLK_ADDR_A = 11'h555;
    localparam logic [UNLK_W-1:0] UNLK_ADDR_B = 11'h2AA;

    localparam logic [7:0] CODE_UNLK_A   = 8'hAA;
    localparam logic [7:0] CODE_UNLK_B   = 8'h55;
    localparam logic [7:0] CODE_PGM      = 8'hA0;
    localparam logic [7:0] CODE_ERASE    = 8'h80;
    localparam logic [7:0] CODE_CHIP     = 8'h10;
    localparam logic [7:0] CODE_SECT     = 8'h30;
    localparam logic [7:0] CODE_ID       = 8'h90;
    localparam logic [7:0] CODE_HOLD     = 8'hB0;
    localparam logic [7:0] CODE_CONTINUE = 8'h30;
    localparam logic [7:0] CODE_ABORT    = 8'hF0;

    typedef enum logic [2:0] {
        REQ_NONE       = 3'd0,
        REQ_PROGRAM    = 3'd1,
        REQ_CHIP_ERASE = 3'd2,
        REQ_SECT_ERASE = 3'd3,
        REQ_SUSPEND    = 3'd4,
        REQ_RESUME     = 3'd5,
        REQ_RESET      = 3'd6
    } req_kind_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNLK1,
        SQ_UNLK2,
        SQ_PGM_SET,
        SQ_ER_SET,
        SQ_ER_UNLK1,
        SQ_ER_UNLK2,
        SQ_SECT_WIN,
        SQ_ID_MODE
    } seq_state_e;

endpackage

// File: rtl/fcd_bus_capture.sv
// Bus write capture: opens a write window when chip select and write strobe
// are both low with output enable high. Takes the address in the window's
// first cycle and keeps following the data until the window closes. When it
// closes, wr_fire pulses for one cycle with the captured pair.
// Assumes the bus strobes are synchronous to clk.
module fcd_bus_capture #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);

    logic              act_now;
    logic              act_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;

    // Write window open: both strobes low, outputs not enabled.
    assign act_now = !ce_n && !we_n && oe_n;

    // Track window state, latch the address at opening and the data while open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            act_q <= act_now;
            if (act_now && !act_q) addr_q <= addr;
            if (act_now)           data_q <= wdata;
        end
    end

    assign wr_fire = act_q && !act_now;
    assign wr_addr = addr_q;
    assign wr_data = data_q;

    // R12: the address does not move while the window stays open.
    p_addr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && act_now) |=> $stable(addr_q));

endmodule

// File: rtl/fcd_seq_tracker.sv
// Command sequence tracker: walks the unlock / setup / command cycles and
// emits one registered request per complete sequence. Busy and suspend come
// from the external operation controller. Wrong cycles fall back to idle.
// Assumes one wr_fire per bus write and arr_rdata valid for wr_addr when it fires.
module fcd_seq_tracker
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        arr_rdata,
    input  logic              busy_in,
    input  logic              suspended_in,
    output logic              in_id_mode,
    output logic              req_valid,
    output req_kind_e         req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data
);

    seq_state_e state_q;
    seq_state_e state_nx;
    req_kind_e  emit_kind;
    req_kind_e  abort_kind;
    logic       sect_run_q;
    logic       at_a;
    logic       at_b;
    logic       is_abort;

    assign at_a       = (wr_addr[UNLK_W-1:0] == UNLK_ADDR_A);
    assign at_b       = (wr_addr[UNLK_W-1:0] == UNLK_ADDR_B);
    assign is_abort   = (wr_data == CODE_ABORT);
    assign abort_kind = suspended_in ? REQ_NONE : REQ_RESET;
    assign in_id_mode = (state_q == SQ_ID_MODE);

    // Next state and request for one write while no operation is running.
    always_comb begin
        state_nx  = SQ_IDLE;
        emit_kind = REQ_NONE;
        unique case (state_q)
            SQ_IDLE: begin
                if (wr_data == CODE_UNLK_A && at_a) begin
                    state_nx = SQ_UNLK1;
                end else if (is_abort) begin
                    emit_kind = abort_kind;
                end else if (suspended_in && wr_data == CODE_CONTINUE) begin
                    emit_kind = REQ_RESUME;
                end
            end
            SQ_UNLK1: begin
                if (wr_data == CODE_UNLK_B && at_b) state_nx = SQ_UNLK2;
                else if (is_abort)                  emit_kind = abort_kind;
            end
            SQ_UNLK2: begin
                if (at_a && wr_data == CODE_ID)                       state_nx = SQ_ID_MODE;
                else if (at_a && wr_data == CODE_PGM)                 state_nx = SQ_PGM_SET;
                else if (at_a && wr_data == CODE_ERASE && !suspended_in) state_nx = SQ_ER_SET;
                else if (is_abort)                                    emit_kind = abort_kind;
            end
            SQ_PGM_SET: begin
                emit_kind = REQ_PROGRAM;
            end
            SQ_ER_SET: begin
                if (wr_data == CODE_UNLK_A && at_a) state_nx = SQ_ER_UNLK1;
                else if (is_abort)                  emit_kind = abort_kind;
            end
            SQ_ER_UNLK1: begin
                if (wr_data == CODE_UNLK_B && at_b) state_nx = SQ_ER_UNLK2;
                else if (is_abort)                  emit_kind = abort_kind;
            end
            SQ_ER_UNLK2: begin
                if (at_a && wr_data == CODE_CHIP) begin
                    emit_kind = REQ_CHIP_ERASE;
                end else if (wr_data == CODE_SECT) begin
                    emit_kind = REQ_SECT_ERASE;
                    state_nx  = SQ_SECT_WIN;
                end else if (is_abort) begin
                    emit_kind = abort_kind;
                end
            end
            SQ_SECT_WIN: begin
                if (wr_data == CODE_SECT) begin
                    emit_kind = REQ_SECT_ERASE;
                    state_nx  = SQ_SECT_WIN;
                end else if (wr_data == CODE_HOLD) begin
                    emit_kind = REQ_SUSPEND;
                end else begin
                    emit_kind = REQ_RESET;
                end
            end
            SQ_ID_MODE: begin
                if (is_abort) emit_kind = abort_kind;
                else          state_nx  = SQ_ID_MODE;
            end
            default: state_nx = SQ_IDLE;
        endcase
    end

    // Sequence state, running-operation kind and request registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            sect_run_q <= 1'b0;
            req_valid  <= 1'b0;
            req_kind   <= REQ_NONE;
            req_addr   <= '0;
            req_data   <= '0;
        end else begin
            req_valid <= 1'b0;
            req_kind  <= REQ_NONE;
            if (busy_in) begin
                if (state_q != SQ_ID_MODE) state_q <= SQ_IDLE;
                if (wr_fire && wr_data == CODE_HOLD && sect_run_q && !suspended_in) begin
                    req_valid <= 1'b1;
                    req_kind  <= REQ_SUSPEND;
                    req_addr  <= wr_addr;
                    req_data  <= wr_data;
                end
            end else if (wr_fire) begin
                state_q <= state_nx;
                if (emit_kind != REQ_NONE) begin
                    req_valid <= 1'b1;
                    req_kind  <= emit_kind;
                    req_addr  <= wr_addr;
                    req_data  <= (emit_kind == REQ_PROGRAM) ? (wr_data & arr_rdata) : wr_data;
                end
                if (emit_kind == REQ_SECT_ERASE) begin
                    sect_run_q <= 1'b1;
                end else if (!suspended_in &&
                             (emit_kind == REQ_CHIP_ERASE || emit_kind == REQ_PROGRAM)) begin
                    sect_run_q <= 1'b0;
                end
            end
        end
    end

    // R7: a request made while busy can only be a suspend.
    p_busy_only_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(busy_in)) |-> (req_kind == REQ_SUSPEND));

    // R2: every request follows a completed bus write.
    p_req_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(wr_fire));

    // R9: identification mode ends only on an abort code write.
    p_id_exit_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_id_mode) |-> $past(wr_fire && wr_data == CODE_ABORT));

endmodule

// File: rtl/fcd_id_reader.sv
// Identification read path: while identification mode is active and a read
// is on the bus, returns the manufacturer code, device code or the addressed
// sector's protect flag, one cycle after the bus inputs.
// Assumes the sector number is the top SECT_W address bits.
module fcd_id_reader #(
    parameter int         SECT_W   = 4,
    parameter logic [7:0] MFR_CODE = 8'h01,
    parameter logic [7:0] DEV_CODE = 8'h38,
    localparam int        SECT_N   = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_id_mode,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [7:0]        offset,
    input  logic [SECT_W-1:0] sector,
    input  logic [SECT_N-1:0] sector_prot,
    output logic              id_valid,
    output logic [7:0]        id_data
);

    logic [7:0] code;
    logic       rd_now;

    assign rd_now = in_id_mode && !ce_n && !oe_n;

    // Select the identification byte for the read offset.
    always_comb begin
        unique case (offset)
            8'h00:   code = MFR_CODE;
            8'h01:   code = DEV_CODE;
            8'h02:   code = {7'b0, sector_prot[sector]};
            default: code = 8'h00;
        endcase
    end

    // Register the read result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_valid <= 1'b0;
            id_data  <= 8'h00;
        end else begin
            id_valid <= rd_now;
            id_data  <= rd_now ? code : 8'h00;
        end
    end

    // R8: identification data only appears after the mode was active.
    p_id_needs_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> $past(in_id_mode));

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: bus capture, sequence tracker and
// identification read path. Requests are single-cycle strobes for an
// external operation controller, which reports busy and suspend back.
// Assumes ADDR_W >= 11 and ADDR_W > SECT_W.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int         ADDR_W   = 20,
    parameter int         SECT_W   = 4,
    parameter logic [7:0] MFR_CODE = 8'h01,
    parameter logic [7:0] DEV_CODE = 8'h38,
    localparam int        SECT_N   = 1 << SECT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_we_n,
    input  logic              bus_oe_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              busy_in,
    input  logic              suspended_in,
    input  logic [SECT_N-1:0] sector_prot,
    input  logic [7:0]        arr_rdata,
    output logic [ADDR_W-1:0] look_addr,
    output logic              req_valid,
    output logic [2:0]        req_kind,
    output logic [ADDR_W-1:0] req_addr,
    output logic [7:0]        req_data,
    output logic              id_valid,
    output logic [7:0]        id_data
);

    logic              wr_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              in_id_mode;
    req_kind_e         kind_e;

    fcd_bus_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (bus_ce_n),
        .we_n    (bus_we_n),
        .oe_n    (bus_oe_n),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .wr_fire (wr_fire),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    fcd_seq_tracker #(.ADDR_W(ADDR_W)) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_fire      (wr_fire),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .arr_rdata    (arr_rdata),
        .busy_in      (busy_in),
        .suspended_in (suspended_in),
        .in_id_mode   (in_id_mode),
        .req_valid    (req_valid),
        .req_kind     (kind_e),
        .req_addr     (req_addr),
        .req_data     (req_data)
    );

    fcd_id_reader #(
        .SECT_W   (SECT_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_id (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_id_mode  (in_id_mode),
        .ce_n        (bus_ce_n),
        .oe_n        (bus_oe_n),
        .offset      (bus_addr[7:0]),
        .sector      (bus_addr[ADDR_W-1 -: SECT_W]),
        .sector_prot (sector_prot),
        .id_valid    (id_valid),
        .id_data     (id_data)
    );

    assign look_addr = wr_addr;
    assign req_kind  = kind_e;

    // R2: a program request never sets a bit that was clear in the old byte.
    p_prog_clears_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 3'd1) |-> ((req_data & ~$past(arr_rdata)) == 8'h00));

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

    localparam int AW = 20;
    localparam int NV = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic          busy = 1'b0, susp = 1'b0;
    logic [15:0]   prot = 16'h0004;
    logic [7:0]    arr_rdata;
    logic [AW-1:0] look_addr;
    logic          req_valid;
    logic [2:0]    req_kind;
    logic [AW-1:0] req_addr;
    logic [7:0]    req_data;
    logic          id_valid;
    logic [7:0]    id_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    // Array model: old byte is a fixed function of the address.
    assign arr_rdata = look_addr[7:0] ^ 8'hC3;

    flash_cmd_decoder i_flash_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_wdata(wdata), .busy_in(busy), .suspended_in(susp),
        .sector_prot(prot), .arr_rdata(arr_rdata), .look_addr(look_addr),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_data(req_data), .id_valid(id_valid), .id_data(id_data)
    );

    // {addr, data, expect valid, expect kind, expect program data}
    localparam logic [39:0] VEC [NV] = '{
        {20'h00555, 8'hAA, 1'b0, 3'd0, 8'h00},
        {20'h002AA, 8'h55, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'hA0, 1'b0, 3'd0, 8'h00},
        {20'h12345, 8'h3C, 1'b1, 3'd1, 8'h04},
        {20'h7F555, 8'hAA, 1'b0, 3'd0, 8'h00},
        {20'hFA2AA, 8'h55, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'h80, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'hAA, 1'b0, 3'd0, 8'h00},
        {20'h002AA, 8'h55, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'h10, 1'b1, 3'd2, 8'h00},
        {20'h00555, 8'hAA, 1'b0, 3'd0, 8'h00},
        {20'h002AB, 8'h55, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'hA0, 1'b0, 3'd0, 8'h00},
        {20'h12345, 8'h3C, 1'b0, 3'd0, 8'h00},
        {20'h002AA, 8'h55, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'hAA, 1'b0, 3'd0, 8'h00},
        {20'h002AA, 8'h5A, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'hA0, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'hAA, 1'b0, 3'd0, 8'h00},
        {20'h002AA, 8'h55, 1'b0, 3'd0, 8'h00},
        {20'h00555, 8'hA0, 1'b0, 3'd0, 8'h00},
        {20'h000FF, 8'hFF, 1'b1, 3'd1, 8'h3C}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus write; returns at the negedge where its request is visible.
    task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d, input logic oe_lvl = 1'b1);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; oe_n = oe_lvl; addr = a; wdata = d;
        @(negedge clk);
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic [AW-1:0] a);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
    endtask

    task automatic rd_end();
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic unlock();
        bus_wr(20'h00555, 8'hAA);
        bus_wr(20'h002AA, 8'h55);
    endtask

    task automatic expect_req(input string tag, input logic v, input logic [2:0] k);
        check(tag, {31'b0, req_valid}, {31'b0, v});
        if (v) check(tag, {29'b0, req_kind}, {29'b0, k});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 req_valid", {31'b0, req_valid}, 0);
        check("R1 req_kind", {29'b0, req_kind}, 0);
        check("R1 id_valid", {31'b0, id_valid}, 0);

        // R2 R3 R5: table of sequences
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            bus_wr(v[39:20], v[19:12]);
            if (v[10:8] == 3'd1)      expect_req("R2 table", v[11], v[10:8]);
            else if (v[10:8] == 3'd2) expect_req("R3 table", v[11], v[10:8]);
            else                      expect_req("R5 table", v[11], v[10:8]);
            if (v[11] && v[10:8] == 3'd1) check("R2 and-data", {24'b0, req_data}, {24'b0, v[7:0]});
        end

        // R6: abort mid-sequence
        unlock();
        bus_wr(20'h00000, 8'hF0);
        expect_req("R6 abort after unlock", 1'b1, 3'd6);
        unlock(); bus_wr(20'h00555, 8'h80); bus_wr(20'h00555, 8'hAA);
        bus_wr(20'h00123, 8'hF0);
        expect_req("R6 abort in erase", 1'b1, 3'd6);

        // R11: strobe with output enable low is no write
        unlock(); bus_wr(20'h00555, 8'hA0);
        bus_wr(20'h00040, 8'h0F, 1'b0);
        expect_req("R11 inhibited", 1'b0, 3'd0);
        bus_wr(20'h00040, 8'hFF);
        expect_req("R11 setup kept", 1'b1, 3'd1);
        check("R11 addr", {12'b0, req_addr}, 32'h40);

        // R12: address at window open, data at window close
        unlock(); bus_wr(20'h00555, 8'hA0);
        @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = 20'h00100; wdata = 8'h11;
        @(negedge clk); addr = 20'h00200; wdata = 8'hF0;
        @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        expect_req("R12 program", 1'b1, 3'd1);
        check("R12 addr", {12'b0, req_addr}, 32'h100);
        check("R12 data", {24'b0, req_data}, 32'hC0);

        // R8: identification reads
        unlock(); bus_wr(20'h00555, 8'h90);
        expect_req("R8 entry", 1'b0, 3'd0);
        bus_rd(20'h00000); check("R8 mfr", {24'b0, id_data}, 32'h01);
        check("R8 valid", {31'b0, id_valid}, 1);
        bus_rd(20'h00001); check("R8 dev", {24'b0, id_data}, 32'h38);
        bus_rd(20'h20002); check("R8 prot sec2", {24'b0, id_data}, 32'h01);
        bus_rd(20'h30002); check("R8 prot sec3", {24'b0, id_data}, 32'h00);
        bus_rd(20'h00005); check("R8 other", {24'b0, id_data}, 32'h00);
        rd_end(); @(negedge clk);
        check("R8 no read", {31'b0, id_valid}, 0);

        // R9: only abort leaves identification mode
        bus_wr(20'h00555, 8'hAA);
        bus_wr(20'h00555, 8'hA0);
        expect_req("R9 ignored", 1'b0, 3'd0);
        bus_rd(20'h00001); check("R9 still id", {24'b0, id_data}, 32'h38);
        rd_end();
        bus_wr(20'h00000, 8'hF0);
        expect_req("R9 exit", 1'b1, 3'd6);
        bus_rd(20'h00000); check("R9 left", {31'b0, id_valid}, 0);
        rd_end();

        // R4: sector erase window
        unlock(); bus_wr(20'h00555, 8'h80); unlock();
        bus_wr(20'h3A000, 8'h30);
        expect_req("R4 first sector", 1'b1, 3'd3);
        check("R4 sector addr", {12'b0, req_addr}, 32'h3A000);
        bus_wr(20'h51234, 8'h30);
        expect_req("R4 second sector", 1'b1, 3'd3);
        bus_wr(20'h00000, 8'hB0);
        expect_req("R4 hold", 1'b1, 3'd4);
        unlock(); bus_wr(20'h00555, 8'h80); unlock();
        bus_wr(20'h60000, 8'h30);
        bus_wr(20'h00555, 8'h55);
        expect_req("R4 stray in window", 1'b1, 3'd6);

        // R10: erase suspended
        susp = 1'b1;
        unlock(); bus_wr(20'h00555, 8'hA0);
        bus_wr(20'h00010, 8'hF3);
        expect_req("R10 program", 1'b1, 3'd1);
        unlock(); bus_wr(20'h00555, 8'h80); unlock();
        bus_wr(20'h00555, 8'h10);
        expect_req("R10 no erase", 1'b0, 3'd0);
        unlock(); bus_wr(20'h00555, 8'h90);
        bus_rd(20'h00001); check("R10 id", {24'b0, id_data}, 32'h38);
        rd_end();
        bus_wr(20'h00000, 8'hF0);
        expect_req("R10 silent exit", 1'b0, 3'd0);
        bus_wr(20'hABCDE, 8'h30);
        expect_req("R10 resume", 1'b1, 3'd5);
        susp = 1'b0;

        // R7: busy with sector erase running
        busy = 1'b1;
        bus_wr(20'h00000, 8'hF0);
        expect_req("R7 abort ignored", 1'b0, 3'd0);
        unlock(); bus_wr(20'h00555, 8'hA0); bus_wr(20'h00020, 8'h00);
        expect_req("R7 program ignored", 1'b0, 3'd0);
        bus_wr(20'h00000, 8'hB0);
        expect_req("R7 hold", 1'b1, 3'd4);
        busy = 1'b0;
        // R7: busy with chip erase running
        unlock(); bus_wr(20'h00555, 8'h80); unlock();
        bus_wr(20'h00555, 8'h10);
        expect_req("R7 chip", 1'b1, 3'd2);
        busy = 1'b1;
        bus_wr(20'h00000, 8'hB0);
        expect_req("R7 hold ignored", 1'b0, 3'd0);
        busy = 1'b0;

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule